// File: doc/BRIEF.md
# Internal-Clock Serial Result Transmitter

This block shifts out the result of the previous conversion over a one-wire serial data line. It makes its own data clock. A conversion-start strobe begins a transmission. On that edge the block captures the held 16-bit word, a flag that says whether the word is a real result, and the current level of a tag input. After a fixed lead delay it sends a burst of exactly sixteen clock pulses. The data goes out most significant bit first. Each bit is set up during the low phase of the clock before the bit's rising edge.

When the burst ends, the data clock stays low. The data line then parks at the captured tag level until the next transmission, so converters can be chained word after word. The lead delay, the high time and the low time are parameters counted in system clocks. While a burst is in progress the block ignores further start strobes. A word captured while the valid flag was low is sent as all zeros.

Top module: `res_ser_tx`

## Requirements
- R1: The word and its valid flag are captured on the clock edge that accepts a start strobe. Changes to `held_word` or `held_ok` after that edge do not alter the bits being sent.
- R2: Each accepted start produces exactly WORD_W (16) rising edges on `sclk_o`. Each pulse is high for HIGH_CYC system cycles, and consecutive rising edges are HIGH_CYC+LOW_CYC cycles apart.
- R3: `sclk_o` is low whenever `busy_o` is low. After reset, `sclk_o`, `sdata_o` and `busy_o` are all 0.
- R4: Bits leave MSB first. Bit k (bit 15 first) is on `sdata_o` across the k-th rising edge and the k-th falling edge. The line changes to the next bit one system cycle after each falling edge.
- R5: `tag_in` is sampled on the accepting edge. From one cycle after the last falling edge, `sdata_o` holds that sampled level until the next accepted start. Later changes of `tag_in` have no effect before then.
- R6: The first rising edge of `sclk_o` comes START_DLY system cycles after the accepting edge.
- R7: A start strobe seen while `busy_o` is high is ignored. This includes a strobe on the edge where the burst ends. No extra pulses follow and the line stays parked.
- R8: If `held_ok` is 0 on the accepting edge, all sixteen bits are sent as 0.
- R9: `busy_o` rises on the accepting edge. It falls one cycle after the sixteenth falling edge, that is START_DLY+15*(HIGH_CYC+LOW_CYC)+HIGH_CYC+1 cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start | input | 1 | Conversion-start strobe, one cycle |
| held_word | input | WORD_W | Result of the previous conversion |
| held_ok | input | 1 | 1 when `held_word` is a valid result |
| tag_in | input | 1 | Level to park the data line at after the word |
| sclk_o | output | 1 | Generated data clock, low when idle |
| sdata_o | output | 1 | Serial data line |
| busy_o | output | 1 | High while a transmission is in progress |

## Verification
A wrong phase counter shows up at once in `sclk_o` as a pulse that is too long or too short. It also moves every later bit boundary, so the cycle-by-cycle comparison over a full burst catches it within one bit period. A wrong pulse counter shows up at the end of the burst. The clock then stops early or late, and the tag level appears at the wrong cycle or `busy_o` falls at the wrong time. A shifter or capture fault corrupts the sampled bit at the first rising edge where the bad bit would be read. Walking-one words point to the exact bit position.

// File: rtl/res_ser_tx_pkg.sv
package res_ser_tx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LEAD = 2'd1,
      ST_HIGH = 2'd2,
      ST_LOW  = 2'd3
   } tx_state_t;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

endpackage

// File: rtl/res_ser_tx_timer.sv
module res_ser_tx_timer
   import res_ser_tx_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter int START_DLY = 27,
   parameter int HIGH_CYC  = 5,
   parameter int LOW_CYC   = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic load_o,
   output logic shift_o,
   output logic busy_o,
   output logic sclk_o
);
   localparam int MAXC = max3(START_DLY, HIGH_CYC, LOW_CYC);
   localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);
   localparam int PW   = $clog2(WORD_W + 1);
   localparam logic [CW-1:0] LEAD_END = CW'(START_DLY - 1);
   localparam logic [CW-1:0] HIGH_END = CW'(HIGH_CYC - 1);
   localparam logic [CW-1:0] LOW_END  = CW'(LOW_CYC - 1);
   localparam logic [PW-1:0] LAST_PULSE = PW'(WORD_W);

   tx_state_t     state_q, state_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic [PW-1:0] npulse_q, npulse_d;
   logic          sclk_q, sclk_d;
   logic          step_pt;

   // first low-phase cycle after a falling edge: data moves here
   assign step_pt = (state_q == ST_LOW) && (cnt_q == '0);

   assign load_o  = (state_q == ST_IDLE) && start_i;
   assign shift_o = step_pt && (npulse_q != LAST_PULSE);
   assign busy_o  = (state_q != ST_IDLE);
   assign sclk_o  = sclk_q;

   always_comb begin
      state_d  = state_q;
      cnt_d    = cnt_q;
      npulse_d = npulse_q;
      sclk_d   = sclk_q;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               state_d  = ST_LEAD;
               cnt_d    = '0;
               npulse_d = '0;
            end
         end
         ST_LEAD: begin
            if (cnt_q == LEAD_END) begin
               state_d = ST_HIGH;
               cnt_d   = '0;
               sclk_d  = 1'b1;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         ST_HIGH: begin
            if (cnt_q == HIGH_END) begin
               state_d  = ST_LOW;
               cnt_d    = '0;
               sclk_d   = 1'b0;
               npulse_d = npulse_q + 1'b1;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         ST_LOW: begin
            if (step_pt && (npulse_q == LAST_PULSE)) begin
               state_d = ST_IDLE;
               cnt_d   = '0;
            end else if (cnt_q == LOW_END) begin
               state_d = ST_HIGH;
               cnt_d   = '0;
               sclk_d  = 1'b1;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cnt_q    <= '0;
         npulse_q <= '0;
         sclk_q   <= 1'b0;
      end else begin
         state_q  <= state_d;
         cnt_q    <= cnt_d;
         npulse_q <= npulse_d;
         sclk_q   <= sclk_d;
      end
   end

   AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      npulse_q <= LAST_PULSE); // R2
   AST_CLK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> !sclk_q); // R3
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && state_q != ST_LOW) |=> busy_o); // R7
endmodule

// File: rtl/res_ser_tx_shreg.sv
module res_ser_tx_shreg #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              shift_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              ok_i,
   output logic              bit_o
);
   logic [WORD_W-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (load_i) begin
         sr_q <= ok_i ? word_i : '0;
      end else if (shift_i) begin
         sr_q <= {sr_q[WORD_W-2:0], 1'b0};
      end
   end

   assign bit_o = sr_q[WORD_W-1];

   AST_ZERO_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !ok_i) |=> (sr_q == '0)); // R8
endmodule

// File: rtl/res_ser_tx_park.sv
module res_ser_tx_park (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic tag_i,
   input  logic busy_i,
   input  logic bit_i,
   output logic line_o
);
   logic tag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tag_q <= 1'b0;
      else if (load_i) tag_q <= tag_i;
   end

   assign line_o = busy_i ? bit_i : tag_q;
endmodule

// File: rtl/res_ser_tx.sv
module res_ser_tx #(
   parameter int WORD_W    = 16,
   parameter int START_DLY = 27,
   parameter int HIGH_CYC  = 5,
   parameter int LOW_CYC   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_start,
   input  logic [WORD_W-1:0] held_word,
   input  logic              held_ok,
   input  logic              tag_in,
   output logic              sclk_o,
   output logic              sdata_o,
   output logic              busy_o
);
   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("res_ser_tx: WORD_W must be at least 2");
      end
      if (START_DLY < 1) begin : g_bad_lead
         $error("res_ser_tx: START_DLY must be at least 1");
      end
      if (HIGH_CYC < 1) begin : g_bad_high
         $error("res_ser_tx: HIGH_CYC must be at least 1");
      end
      if (LOW_CYC < 2) begin : g_bad_low
         $error("res_ser_tx: LOW_CYC must be at least 2 so data settles in the low phase");
      end
   endgenerate

   logic load_w, shift_w, busy_w, sclk_w, bit_w, line_w;

   res_ser_tx_timer #(
      .WORD_W(WORD_W), .START_DLY(START_DLY),
      .HIGH_CYC(HIGH_CYC), .LOW_CYC(LOW_CYC)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .start_i(conv_start),
      .load_o(load_w), .shift_o(shift_w), .busy_o(busy_w), .sclk_o(sclk_w)
   );

   res_ser_tx_shreg #(.WORD_W(WORD_W)) u_shreg (
      .clk(clk), .rst_n(rst_n), .load_i(load_w), .shift_i(shift_w),
      .word_i(held_word), .ok_i(held_ok), .bit_o(bit_w)
   );

   res_ser_tx_park u_park (
      .clk(clk), .rst_n(rst_n), .load_i(load_w), .tag_i(tag_in),
      .busy_i(busy_w), .bit_i(bit_w), .line_o(line_w)
   );

   assign sclk_o  = sclk_w;
   assign sdata_o = line_w;
   assign busy_o  = busy_w;

   AST_BIT_STABLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk_o) |-> $stable(sdata_o)); // R4
   AST_BIT_STABLE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk_o) |-> $stable(sdata_o)); // R4
   AST_PARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && $past(!busy_o)) |-> $stable(sdata_o)); // R5
   AST_END_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (!sclk_o && !$past(sclk_o))); // R9
endmodule

// File: tb/sim_res_ser_tx.sv
module sim_res_ser_tx;
   localparam int CLK_PER = 10;
   localparam int W  = 16;
   localparam int D  = 3;
   localparam int H  = 2;
   localparam int L  = 3;
   localparam int P  = H + L;
   localparam int ENDC = D + 15 * P + H + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic conv_start = 1'b0;
   logic [W-1:0] held_word = '0;
   logic held_ok = 1'b0;
   logic tag_in = 1'b0;
   logic sclk_o, sdata_o, busy_o;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   res_ser_tx #(.WORD_W(W), .START_DLY(D), .HIGH_CYC(H), .LOW_CYC(L)) u0 (
      .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .held_word(held_word),
      .held_ok(held_ok), .tag_in(tag_in), .sclk_o(sclk_o), .sdata_o(sdata_o),
      .busy_o(busy_o)
   );

   always #(CLK_PER/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // m = index of the last edge since the accepting edge (0 = accepting edge)
   function automatic bit exp_sclk(input int m);
      return (m >= D) && (m < D + 16 * P) && (((m - D) % P) < H);
   endfunction

   function automatic int bit_idx(input int m);
      int j;
      if (m < D + H + 1) j = 0;
      else j = (m - D - H - 1) / P + 1;
      if (j > 16) j = 16;
      return j;
   endfunction

   task automatic burst(input logic [W-1:0] w, input bit ok, input bit tg,
                        input int strobe_at, input int tagflip_at, input int wchg_at);
      int rises;
      bit prev;
      rises = 0;
      prev = 1'b0;
      @(negedge clk);
      held_word = w; held_ok = ok; tag_in = tg; conv_start = 1'b1;
      @(posedge clk);
      for (int m = 0; m <= ENDC + 6; m++) begin
         int j;
         bit e_data;
         @(negedge clk);
         conv_start = (m == strobe_at);
         if (m == tagflip_at) tag_in = ~tg;
         if (m == wchg_at) begin held_word = ~w; held_ok = ~ok; end
         j = bit_idx(m);
         if (j >= 16 || m >= ENDC) e_data = tg;
         else e_data = ok ? w[15 - j] : 1'b0;
         if (m >= ENDC) e_data = tg;
         // R2 R3 R6: clock waveform incl. first rise after D cycles and idle low
         chk(sclk_o == exp_sclk(m), "R2/R6 sclk", sclk_o, exp_sclk(m));
         // R4 R1 R8 R5: serial line contents
         chk(sdata_o == e_data, "R4/R1/R8/R5 sdata", sdata_o, e_data);
         // R9 R7: busy span
         chk(busy_o == (m < ENDC), "R9/R7 busy", busy_o, (m < ENDC));
         if (sclk_o && !prev) rises++;
         prev = sclk_o;
      end
      chk(rises == 16, "R2 pulse count", rises, 16);
      conv_start = 1'b0;
      tag_in = tg;
   endtask

   initial begin
      repeat (1000 * (ENDC + 10)) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(sclk_o == 1'b0, "R3 reset sclk", sclk_o, 0);
      chk(sdata_o == 1'b0, "R3 reset sdata", sdata_o, 0);
      chk(busy_o == 1'b0, "R3 reset busy", busy_o, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R7: strobe held idle-time check not started without strobe
      chk(busy_o == 1'b0, "R3 idle busy", busy_o, 0);

      // R4: walking ones over every bit position, alternating tag
      for (int b = 0; b < W; b++) begin
         burst(W'(1) << b, 1'b1, b[0], -1, -1, -1);
      end
      // R4: walking zeros
      for (int b = 0; b < W; b++) begin
         burst(~(W'(1) << b), 1'b1, ~b[0], -1, -1, -1);
      end
      burst(16'h0000, 1'b1, 1'b1, -1, -1, -1);
      burst(16'hFFFF, 1'b1, 1'b0, -1, -1, -1);
      burst(16'hA5C3, 1'b1, 1'b1, -1, -1, -1);
      // R8: invalid result sends zeros
      burst(16'hFFFF, 1'b0, 1'b1, -1, -1, -1);
      burst(16'h5A3C, 1'b0, 1'b0, -1, -1, -1);
      // R1: word and valid change after capture
      burst(16'h8001, 1'b1, 1'b0, -1, -1, 0);
      burst(16'h7E11, 1'b1, 1'b1, -1, -1, D + 4 * P);
      // R5: tag changes mid-burst and after the word
      burst(16'h1234, 1'b1, 1'b1, -1, 2, -1);
      burst(16'h4321, 1'b1, 1'b0, -1, ENDC + 1, -1);
      // R7: strobes during lead, mid-burst, and on the ending edge
      burst(16'hC00F, 1'b1, 1'b1, 0, -1, -1);
      burst(16'h0FF0, 1'b1, 1'b0, D + 7 * P, -1, -1);
      burst(16'h9999, 1'b1, 1'b1, ENDC - 1, -1, -1);
      // back-to-back: next start right after busy falls
      burst(16'h6006, 1'b1, 1'b0, -1, -1, -1);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule